// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss without software help. The requester gives it a virtual address and the kind of access it wants (read, write or instruction fetch). The walker works out where the page table entry for that virtual page sits in memory, issues exactly one read for it on a plain request/valid memory port, and then judges the returned entry. If the page is resident and its rights allow the access, the walker returns the physical address. If not, it returns a fault with a cause code and keeps the faulting virtual page number for later inspection.

The page table is one flat array that starts at a base address held inside the walker. Software reloads that base when the running process changes. A base write that arrives while a walk is under way is held back and only applied once that walk has delivered its result. The faulting access is never allowed to complete: a faulting result carries no physical address, so no write can be steered anywhere.

Top module: `page_walker`

## Requirements
- R1: After a synchronous active-low reset, busy, done, mem_req and resp_fault are 0, resp_cause is 0, resp_paddr is 0, fault_vpn is 0 and the table base is 0.
- R2: A request (req_valid high) is taken only while busy is low; req_valid while busy is high is ignored and changes neither the memory read nor the result of the walk under way.
- R3: Each accepted request produces exactly one memory read: mem_req is high for one cycle, in the cycle after acceptance, with mem_addr equal to the table base plus four times the virtual page number (VPN = req_vaddr above the page offset).
- R4: An entry whose bit 31 is 0 is not resident: the result is a fault with resp_cause 1.
- R5: Entry bits 30:29 give the rights: 0 read-only, 1 read/write, 2 execute-only, 3 read/write/execute. req_access is 0 read, 1 write, 2 execute, 3 reserved. A resident entry whose rights do not cover the access (the reserved code is never covered) gives a fault with resp_cause 2.
- R6: A resident entry with sufficient rights gives resp_fault 0, resp_cause 0 and resp_paddr equal to entry bits 21:0 placed above the unchanged 12-bit page offset.
- R7: On a fault resp_fault is 1 and resp_paddr is 0; fault_vpn takes the faulting VPN and holds it through later successful walks until the next fault.
- R8: A base write (base_wr_en) while busy is low takes effect for the next walk, including one accepted in the same cycle; base writes while busy is high are deferred until the walk ends, the last one winning, and never change the address of the walk under way.
- R9: busy stays high from the cycle after acceptance until done; done is a one-cycle pulse four cycles after the cycle in which mem_rvalid arrives counts as cycle 2, i.e. done appears in cycle 4+L after acceptance when the entry returns L cycles after the earliest possible cycle, and result outputs hold until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Load the table base |
| base_wr_data | input | 34 | New table base (physical byte address) |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 34 | Address of the table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry |
| done | output | 1 | Result valid pulse |
| resp_fault | output | 1 | Result is a fault |
| resp_cause | output | 2 | 0 none, 1 not resident, 2 protection |
| resp_paddr | output | 34 | Translated physical address |
| fault_vpn | output | 20 | VPN of the latest faulting walk |

## Verification
The checker watches on every cycle that a read strobe lasts one cycle and only during a walk, that done is a lone pulse followed by idle, that a fault never carries an address and always a non-zero cause, and that a good translation keeps the offset it was given while a fault records the accepted page number. Which cause each rights/access pair yields, where a deferred base lands, the latency of each walk and that a request during a walk is dropped can only be shown by the bench scenarios, with the reference model tracking every output cycle by cycle.

// File: rtl/ptw_pkg.sv
// Shared types and encodings for the page table walker.
// Assumes one 32-bit table entry per virtual page.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_CHECK,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ABSENT  = 2'd1,
        CAUSE_RIGHTS  = 2'd2
    } fault_cause_t;

    localparam int ENTRY_W      = 32;
    localparam int PRESENT_BIT  = 31;
    localparam int RIGHTS_HI    = 30;
    localparam int RIGHTS_LO    = 29;
    localparam int ENTRY_SHIFT  = 2;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    localparam logic [1:0] RG_RO  = 2'd0;
    localparam logic [1:0] RG_RW  = 2'd1;
    localparam logic [1:0] RG_X   = 2'd2;
    localparam logic [1:0] RG_RWX = 2'd3;

endpackage

// File: rtl/ptw_base_reg.sv
// Table base register with deferred update.
// Writes while idle land at once; writes during a walk are parked and
// applied at the final cycle of that walk, the newest write winning.
module ptw_base_reg #(
    parameter int PA_W = 34
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            busy,
    input  logic            walk_end,
    output logic [PA_W-1:0] base
);

    logic [PA_W-1:0] park_q;
    logic            park_v_q;

    // Update the live base or the parked value depending on walk status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base     <= '0;
            park_q   <= '0;
            park_v_q <= 1'b0;
        end else if (!busy) begin
            if (wr_en) base <= wr_data;
        end else if (walk_end) begin
            if (wr_en)         base <= wr_data;
            else if (park_v_q) base <= park_q;
            park_v_q <= 1'b0;
        end else if (wr_en) begin
            park_q   <= wr_data;
            park_v_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ptw_entry_check.sv
// Judges a fetched table entry against the requested access.
// Purely combinational; assumes PPN_W fits below the rights field.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int PPN_W = 22
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         access,
    output logic               fault,
    output fault_cause_t       cause,
    output logic [PPN_W-1:0]   ppn
);

    logic [1:0] rights;
    logic       allowed;

    assign rights = entry[RIGHTS_HI:RIGHTS_LO];
    assign ppn    = entry[PPN_W-1:0];

    // Decide whether the rights field covers the access kind.
    always_comb begin
        unique case (rights)
            RG_RO:   allowed = (access == ACC_READ);
            RG_RW:   allowed = (access == ACC_READ) || (access == ACC_WRITE);
            RG_X:    allowed = (access == ACC_EXEC);
            default: allowed = (access != 2'd3);
        endcase
    end

    // Rank the fault reasons: absence first, then rights.
    always_comb begin
        if (!entry[PRESENT_BIT]) begin
            fault = 1'b1;
            cause = CAUSE_ABSENT;
        end else if (!allowed) begin
            fault = 1'b1;
            cause = CAUSE_RIGHTS;
        end else begin
            fault = 1'b0;
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/page_walker.sv
// Single-level page table walker.
// Takes one request at a time, reads one entry at base + VPN*4, checks
// residency and rights, and reports a translation or a fault.
// Assumes the memory answers every read with exactly one mem_rvalid.
module page_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PPN_W = 22,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr_en,
    input  logic [PA_W-1:0]  base_wr_data,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_access,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             done,
    output logic             resp_fault,
    output logic [1:0]       resp_cause,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [VPN_W-1:0] fault_vpn
);

    walk_state_t         state_q;
    logic [VPN_W-1:0]    vpn_q;
    logic [OFF_W-1:0]    off_q;
    logic [1:0]          acc_q;
    logic [ENTRY_W-1:0]  entry_q;
    logic [PA_W-1:0]     base;
    logic                chk_fault;
    fault_cause_t        chk_cause;
    logic [PPN_W-1:0]    chk_ppn;

    assign busy    = (state_q != ST_IDLE);
    assign mem_req = (state_q == ST_READ);
    assign done    = (state_q == ST_DONE);
    assign mem_addr = base + PA_W'({vpn_q, {ENTRY_SHIFT{1'b0}}});

    ptw_base_reg #(.PA_W(PA_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (base_wr_en),
        .wr_data  (base_wr_data),
        .busy     (busy),
        .walk_end (done),
        .base     (base)
    );

    ptw_entry_check #(.PPN_W(PPN_W)) u_check (
        .entry  (entry_q),
        .access (acc_q),
        .fault  (chk_fault),
        .cause  (chk_cause),
        .ppn    (chk_ppn)
    );

    // Walk sequencing: accept, read, wait, judge, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            off_q   <= '0;
            acc_q   <= '0;
            entry_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vpn_q   <= req_vaddr[VA_W-1:OFF_W];
                    off_q   <= req_vaddr[OFF_W-1:0];
                    acc_q   <= req_access;
                    state_q <= ST_READ;
                end
                ST_READ: state_q <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) begin
                    entry_q <= mem_rdata;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers, written once per walk and held until the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_fault <= 1'b0;
            resp_cause <= CAUSE_NONE;
            resp_paddr <= '0;
            fault_vpn  <= '0;
        end else if (state_q == ST_CHECK) begin
            resp_fault <= chk_fault;
            resp_cause <= chk_cause;
            resp_paddr <= chk_fault ? '0 : {chk_ppn, off_q};
            if (chk_fault) fault_vpn <= vpn_q;
        end
    end

endmodule

// File: rtl/ptw_checker.sv
// Temporal checks on the walker's ports; bound to every page_walker.
// Keeps its own copy of the accepted page number and offset.
module ptw_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PPN_W = 22,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             busy,
    input logic             mem_req,
    input logic             done,
    input logic             resp_fault,
    input logic [1:0]       resp_cause,
    input logic [PA_W-1:0]  resp_paddr,
    input logic [VPN_W-1:0] fault_vpn
);

    logic [VPN_W-1:0] vpn_seen;
    logic [OFF_W-1:0] off_seen;

    // Record what the walker accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_seen <= '0;
            off_seen <= '0;
        end else if (req_valid && !busy) begin
            vpn_seen <= req_vaddr[VA_W-1:OFF_W];
            off_seen <= req_vaddr[OFF_W-1:0];
        end
    end

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R3
    AST_READ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R2
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy) |=> (busy && !done)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R9
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (done && resp_fault) |-> (resp_paddr == '0 && resp_cause != 2'd0)); // R7
    AST_GOOD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (done && !resp_fault) |-> (resp_cause == 2'd0)); // R6
    AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (done && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == off_seen)); // R6
    AST_FAULT_VPN: assert property (@(posedge clk) disable iff (!rst_n) (done && resp_fault) |-> (fault_vpn == vpn_seen)); // R7

endmodule

bind page_walker ptw_checker #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PPN_W (PPN_W)
) u_ptw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .busy       (busy),
    .mem_req    (mem_req),
    .done       (done),
    .resp_fault (resp_fault),
    .resp_cause (resp_cause),
    .resp_paddr (resp_paddr),
    .fault_vpn  (fault_vpn)
);

// File: tb/tb_page_walker.sv
// Bench: memory model, cycle-by-cycle reference model, directed scenarios.
module tb_page_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [33:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        busy, mem_req, done, resp_fault;
    logic [33:0] mem_addr, resp_paddr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  resp_cause;
    logic [19:0] fault_vpn;

    page_walker dut (
        .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_access(req_access),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .resp_fault(resp_fault), .resp_cause(resp_cause), .resp_paddr(resp_paddr),
        .fault_vpn(fault_vpn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [33:0]];
    int          lat = 0;
    bit          rd_pend = 0;
    int          rd_cnt = 0;
    logic [33:0] rd_addr = '0;
    logic [33:0] last_addr = '0;
    int          reads = 0;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
                rd_pend    = 0;
            end else rd_cnt--;
        end
        if (rst_n && mem_req) begin
            rd_pend   = 1;
            rd_cnt    = lat;
            rd_addr   = mem_addr;
            last_addr = mem_addr;
            reads++;
        end
    end

    // ---------------- reference model ----------------
    int          ph = 0;
    logic [33:0] m_base = '0, m_park = '0;
    bit          m_pv = 0;
    logic [19:0] m_vpn = '0;
    logic [11:0] m_off = '0;
    logic [1:0]  m_acc = '0;
    logic [31:0] m_ent = '0;
    logic [33:0] e_pa = '0;
    logic        e_f = 0;
    logic [1:0]  e_c = '0;
    logic [19:0] e_fv = '0;
    bit          started = 0;

    function automatic logic [1:0] ref_cause(input logic [31:0] ent, input logic [1:0] acc);
        logic [3:0] mask;
        case (ent[30:29])
            2'd0: mask = 4'b0001;
            2'd1: mask = 4'b0011;
            2'd2: mask = 4'b0100;
            default: mask = 4'b0111;
        endcase
        if (ent[31] == 1'b0) return 2'd1;
        if (mask[acc] == 1'b0) return 2'd2;
        return 2'd0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            ph = 0; m_base = '0; m_pv = 0; e_pa = '0; e_f = 0; e_c = '0; e_fv = '0;
        end else begin
            if (ph != 0 && ph != 4 && base_wr_en) begin m_park = base_wr_data; m_pv = 1; end
            case (ph)
                0: begin
                    if (base_wr_en) m_base = base_wr_data;
                    if (req_valid) begin
                        m_vpn = req_vaddr[31:12]; m_off = req_vaddr[11:0]; m_acc = req_access; ph = 1;
                    end
                end
                1: ph = 2;
                2: if (mem_rvalid) begin m_ent = mem_rdata; ph = 3; end
                3: begin
                    e_c = ref_cause(m_ent, m_acc);
                    e_f = (e_c != 0);
                    e_pa = e_f ? 34'h0 : {m_ent[21:0], m_off};
                    if (e_f) e_fv = m_vpn;
                    ph = 4;
                end
                default: begin
                    if (base_wr_en) m_base = base_wr_data;
                    else if (m_pv) m_base = m_park;
                    m_pv = 0; ph = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R9 busy", busy, ph != 0);
            chk("R9 done", done, ph == 4);
            chk("R3 mem_req", mem_req, ph == 1);
            if (ph == 1) chk("R3 mem_addr", mem_addr, m_base + {m_vpn, 2'b00});
            chk("R6 resp_paddr", resp_paddr, e_pa);
            chk("R7 resp_fault", resp_fault, e_f);
            chk("R5 resp_cause", resp_cause, e_c);
            chk("R7 fault_vpn", fault_vpn, e_fv);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mk(input bit v, input logic [1:0] rg, input logic [21:0] ppn);
        return {v, rg, 7'b0, ppn};
    endfunction

    task automatic set_base(input logic [33:0] b);
        @(negedge clk);
        base_wr_en = 1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 0;
    endtask

    bit          mid_req = 0;
    bit          mid_base = 0;

    task automatic walk(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] acc,
                        input int l, output int cyc);
        lat = l;
        @(negedge clk);
        req_valid = 1; req_vaddr = {vpn, off}; req_access = acc;
        cyc = 0;
        for (int n = 1; n < 60; n++) begin
            @(negedge clk);
            req_valid = 0; base_wr_en = 0;
            if (mid_req && n == 1) begin req_valid = 1; req_vaddr = 32'h0006_3abc; req_access = 2'd3; end
            if (mid_base && n == 2) begin base_wr_en = 1; base_wr_data = 34'h8000; end
            if (mid_base && n == 3) begin base_wr_en = 1; base_wr_data = 34'h9000; end
            if (done) begin cyc = n; break; end
        end
        req_valid = 0; base_wr_en = 0;
    endtask

    int cyc;
    int r0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 cause", resp_cause, 0);
        chk("R1 paddr", resp_paddr, 0);
        chk("R1 fault_vpn", fault_vpn, 0);
        rst_n = 1;
        @(negedge clk);

        set_base(34'h1000);
        mem[34'h1000 + 5*4]  = mk(1, 2'd1, 22'h12345);
        mem[34'h1000 + 6*4]  = mk(1, 2'd0, 22'h00aaa);
        mem[34'h1000 + 7*4]  = mk(1, 2'd2, 22'h00bbb);
        mem[34'h1000 + 8*4]  = mk(0, 2'd3, 22'h3ffff);
        mem[34'h1000 + 9*4]  = mk(1, 2'd3, 22'h00ccc);

        // R6 R3: read on read/write page
        walk(20'd5, 12'h7f3, 2'd0, 0, cyc);
        chk("R6 paddr", resp_paddr, {22'h12345, 12'h7f3});
        chk("R6 fault", resp_fault, 0);
        chk("R3 addr", last_addr, 34'h1000 + 20);
        chk("R9 latency L=0", cyc, 4);

        // R5: write on read-only page
        walk(20'd6, 12'h001, 2'd1, 2, cyc);
        chk("R5 cause RO write", resp_cause, 2);
        chk("R7 paddr zero", resp_paddr, 0);
        chk("R7 fault_vpn", fault_vpn, 6);
        chk("R9 latency L=2", cyc, 6);

        // R5: execute page
        walk(20'd7, 12'h010, 2'd2, 1, cyc);
        chk("R5 exec ok", resp_cause, 0);
        chk("R7 fault_vpn held", fault_vpn, 6);
        walk(20'd7, 12'h010, 2'd0, 0, cyc);
        chk("R5 read on exec page", resp_cause, 2);
        walk(20'd9, 12'h020, 2'd3, 0, cyc);
        chk("R5 reserved access", resp_cause, 2);
        walk(20'd9, 12'h020, 2'd1, 0, cyc);
        chk("R5 write on rwx", resp_paddr, {22'h00ccc, 12'h020});

        // R4: not resident, rights irrelevant
        walk(20'd8, 12'h000, 2'd0, 3, cyc);
        chk("R4 cause", resp_cause, 1);
        chk("R4 fault", resp_fault, 1);
        chk("R7 fault_vpn latched", fault_vpn, 8);
        // unmapped address also reads as absent
        walk(20'd200, 12'h000, 2'd0, 0, cyc);
        chk("R4 unmapped", resp_cause, 1);

        // R2: request during walk ignored
        r0 = reads;
        mid_req = 1;
        walk(20'd5, 12'h444, 2'd1, 2, cyc);
        mid_req = 0;
        chk("R2 one read", reads - r0, 1);
        chk("R2 result of first", resp_paddr, {22'h12345, 12'h444});
        repeat (3) @(negedge clk);
        chk("R2 no second walk", reads - r0, 1);
        chk("R2 idle", busy, 0);

        // R8: base writes during walk deferred, last wins
        mem[34'h9000 + 3*4] = mk(1, 2'd1, 22'h00777);
        mem[34'h1000 + 3*4] = mk(1, 2'd1, 22'h00111);
        mid_base = 1;
        walk(20'd3, 12'h0ab, 2'd0, 3, cyc);
        mid_base = 0;
        chk("R8 old base used", last_addr, 34'h1000 + 12);
        chk("R8 old table result", resp_paddr, {22'h00111, 12'h0ab});
        walk(20'd3, 12'h0ab, 2'd0, 0, cyc);
        chk("R8 new base", last_addr, 34'h9000 + 12);
        chk("R8 new table result", resp_paddr, {22'h00777, 12'h0ab});

        // R8: base write in the accepting cycle applies to that walk
        mem[34'h2000 + 3*4] = mk(1, 2'd1, 22'h00222);
        @(negedge clk);
        base_wr_en = 1; base_wr_data = 34'h2000;
        req_valid = 1; req_vaddr = {20'd3, 12'h0ab}; req_access = 2'd0;
        @(negedge clk);
        base_wr_en = 0; req_valid = 0;
        repeat (6) @(negedge clk);
        chk("R8 same-cycle base", last_addr, 34'h2000 + 12);
        chk("R8 same-cycle result", resp_paddr, {22'h00222, 12'h0ab});

        // R1: reset again mid-state clears results
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 cleared fault_vpn", fault_vpn, 0);
        chk("R1 cleared paddr", resp_paddr, 0);
        walk(20'd0, 12'h000, 2'd0, 0, cyc);
        chk("R1 base zero after reset", last_addr, 34'h0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule